// File: doc/BRIEF.md
# Serial Clock Register Bank Front End

This block sits between a bit-level serial-bus slave and the timekeeping core of a clock-calendar device with a small battery-backed memory. The bus slave hands it decoded events, one per cycle: a start addressed for writing, a start addressed for reading, a received byte, and a byte taken by the master. In return the block keeps a 64-byte bank made of seven time/date bytes, one control byte and 56 bytes of general memory, together with a register pointer that steps forward by itself.

The time/date bytes are not live counters. They form a snapshot of the core's time that is refreshed when a read begins and again each time the pointer wraps around. A master therefore reads a set of values that belong together, even if the seconds roll over during the transfer. Writes to the time/date locations are not stored in the bank. They go to the timekeeping core as a one-cycle load pulse carrying an index and a data byte. The control byte has three bits that always read as zero, and an oscillator-stopped flag. The core sets that flag, and software can clear it but cannot set it.

Top module: `rtc_front`

## Requirements
- R1: Reset sets all 64 bank bytes, including the control byte, to zero, sets the pointer to 0, and leaves the block not expecting an address byte. Reading the whole bank after reset returns zeros.
- R2: The first byte received after a write-start is taken as a register address. The pointer loads its low 6 bits and the byte is not stored. When several events arrive in one cycle, the priority is write-start, then read-start, then received byte, then byte taken.
- R3: Every later received byte advances the pointer by one modulo 64. A byte aimed at locations 8 to 63 is stored there.
- R4: txData always shows the byte at the pointer, combinationally. Each txTake pulse advances the pointer by one modulo 64.
- R5: A read-start copies liveTime into locations 0 to 6, with location i taking liveTime[8i+7:8i]. The first byte returned after it comes from that copy. The pointer is unchanged.
- R6: When the pointer steps from 63 to 0, by a read or by a write, liveTime is copied again into locations 0 to 6 in the same cycle.
- R7: A byte written to locations 0 to 6 leaves the bank unchanged. In the next cycle it gives loadStb high for one cycle, with loadIdx equal to the location and loadData equal to the byte.
- R8: A byte written to location 7 is ANDed with 0xB3, so bits 2, 3 and 6 of the control byte always read as zero.
- R9: Writing 0 to control bit 5 clears it. Writing 1 to it leaves its previous value unchanged.
- R10: oscStop high at a clock edge sets control bit 5. This takes precedence over a clearing write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startWr | input | 1 | Start condition addressed for writing |
| startRd | input | 1 | Start condition addressed for reading |
| rxValid | input | 1 | A received data byte is on rxData |
| rxData | input | 8 | Received byte |
| txTake | input | 1 | Master has taken the byte on txData |
| txData | output | 8 | Byte at the register pointer |
| liveTime | input | 56 | Current time bytes from the core, byte i in bits 8i+7:8i |
| oscStop | input | 1 | Oscillator-stopped event from the core |
| loadStb | output | 1 | One-cycle load pulse for a time/date byte |
| loadIdx | output | 3 | Time/date location being loaded |
| loadData | output | 8 | Byte to load |

## Verification
The hardest case to reach from the ports is the wraparound recapture. The pointer has to sit at 63 while a write or a read advances it, and the changing liveTime value must be visible at location 0 on the next read. A second hard case is a clearing write to the control byte in the same cycle that oscStop rises. Directed sequences steer the pointer to 62 and 63 and line up oscStop with a control write. A seeded random mix of write bursts, read bursts, stray take pulses and random liveTime values then crosses the wrap many more times, and every returned byte is compared with a bench reference model.

// File: rtl/rtc_front_pkg.sv
package rtc_front_pkg;
  // Strobes issued by the control unit to the register bank
  typedef struct packed {
    logic capture;   // copy live time into the time/date bytes
    logic storeRam;  // store received byte at pointer (general memory)
    logic storeCtrl; // merge received byte into control byte
    logic loadTime;  // forward received byte to timekeeping core
  } frontStrb_t;
endpackage

// File: rtl/rtc_front_ctrl.sv
module rtc_front_ctrl
  import rtc_front_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int TIME_REGS = 7,
  parameter int CTRL_IDX  = 7,
  localparam int IDX_W    = $clog2(TIME_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startWr,
  input  logic              startRd,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              txTake,
  output frontStrb_t        strb,
  output logic [ADDR_W-1:0] regPtr,
  output logic              expectAddr,
  output logic              loadStb,
  output logic [IDX_W-1:0]  loadIdx,
  output logic [7:0]        loadData
);
  localparam logic [ADDR_W-1:0] PTR_LAST = '1;

  logic ptrLoad;
  logic ptrInc;
  logic byteIn;

  assign byteIn = rxValid && !startWr && !startRd;

  always_comb begin
    strb    = '0;
    ptrLoad = 1'b0;
    ptrInc  = 1'b0;
    if (startWr) begin
      // only arms the address phase
    end else if (startRd) begin
      strb.capture = 1'b1;
    end else if (rxValid) begin
      if (expectAddr) begin
        ptrLoad = 1'b1;
      end else begin
        ptrInc = 1'b1;
        if (int'(regPtr) < TIME_REGS)       strb.loadTime  = 1'b1;
        else if (int'(regPtr) == CTRL_IDX)  strb.storeCtrl = 1'b1;
        else                                strb.storeRam  = 1'b1;
      end
    end else if (txTake) begin
      ptrInc = 1'b1;
    end
    if (ptrInc && regPtr == PTR_LAST) strb.capture = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      expectAddr <= 1'b0;
      regPtr     <= '0;
      loadStb    <= 1'b0;
      loadIdx    <= '0;
      loadData   <= '0;
    end else begin
      if (startWr)     expectAddr <= 1'b1;
      else if (byteIn) expectAddr <= 1'b0;

      if (ptrLoad)     regPtr <= rxData[ADDR_W-1:0];
      else if (ptrInc) regPtr <= regPtr + 1'b1;

      loadStb <= strb.loadTime;
      if (strb.loadTime) begin
        loadIdx  <= regPtr[IDX_W-1:0];
        loadData <= rxData;
      end
    end
  end
endmodule

// File: rtl/rtc_front_data.sv
module rtc_front_data
  import rtc_front_pkg::*;
#(
  parameter int          ADDR_W    = 6,
  parameter int          TIME_REGS = 7,
  parameter int          CTRL_IDX  = 7,
  parameter logic [7:0]  CTRL_KEEP = 8'hB3,
  parameter int          OSF_BIT   = 5,
  localparam int         DEPTH     = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  frontStrb_t             strb,
  input  logic [ADDR_W-1:0]      regPtr,
  input  logic [7:0]             wrData,
  input  logic [TIME_REGS*8-1:0] liveTime,
  input  logic                   oscStop,
  output logic [7:0]             txData,
  output logic [7:0]             ctrlByte
);
  logic [7:0] bank [DEPTH];
  logic [7:0] ctrlNext;

  // control byte: masked write, flag clear-only by software, set by core
  always_comb begin
    ctrlNext = bank[CTRL_IDX];
    if (strb.storeCtrl) begin
      ctrlNext          = wrData & CTRL_KEEP;
      ctrlNext[OSF_BIT] = wrData[OSF_BIT] & bank[CTRL_IDX][OSF_BIT];
    end
    if (oscStop) ctrlNext[OSF_BIT] = 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_loc
    if (g < TIME_REGS) begin : g_time
      always_ff @(posedge clk) begin
        if (!rstN)             bank[g] <= '0;
        else if (strb.capture) bank[g] <= liveTime[g*8 +: 8];
      end
    end else if (g == CTRL_IDX) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (!rstN) bank[g] <= '0;
        else       bank[g] <= ctrlNext;
      end
    end else begin : g_ram
      always_ff @(posedge clk) begin
        if (!rstN)                                  bank[g] <= '0;
        else if (strb.storeRam && int'(regPtr) == g) bank[g] <= wrData;
      end
    end
  end

  assign txData   = bank[regPtr];
  assign ctrlByte = bank[CTRL_IDX];
endmodule

// File: rtl/rtc_front.sv
module rtc_front
  import rtc_front_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int TIME_REGS = 7,
  parameter int CTRL_IDX  = 7,
  localparam int IDX_W    = $clog2(TIME_REGS)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startWr,
  input  logic                   startRd,
  input  logic                   rxValid,
  input  logic [7:0]             rxData,
  input  logic                   txTake,
  output logic [7:0]             txData,
  input  logic [TIME_REGS*8-1:0] liveTime,
  input  logic                   oscStop,
  output logic                   loadStb,
  output logic [IDX_W-1:0]       loadIdx,
  output logic [7:0]             loadData
);
  frontStrb_t        strb;
  logic [ADDR_W-1:0] regPtr;
  logic              expectAddr;
  logic [7:0]        ctrlByte;

  rtc_front_ctrl #(.ADDR_W(ADDR_W), .TIME_REGS(TIME_REGS), .CTRL_IDX(CTRL_IDX)) u_ctrl (
    .clk(clk), .rstN(rstN), .startWr(startWr), .startRd(startRd),
    .rxValid(rxValid), .rxData(rxData), .txTake(txTake), .strb(strb),
    .regPtr(regPtr), .expectAddr(expectAddr), .loadStb(loadStb),
    .loadIdx(loadIdx), .loadData(loadData)
  );

  rtc_front_data #(.ADDR_W(ADDR_W), .TIME_REGS(TIME_REGS), .CTRL_IDX(CTRL_IDX)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .regPtr(regPtr), .wrData(rxData),
    .liveTime(liveTime), .oscStop(oscStop), .txData(txData), .ctrlByte(ctrlByte)
  );
endmodule

// File: rtl/rtc_front_chk.sv
module rtc_front_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              startWr,
  input logic              startRd,
  input logic              rxValid,
  input logic [7:0]        rxData,
  input logic              txTake,
  input logic [7:0]        txData,
  input logic              oscStop,
  input logic              loadStb,
  input logic [2:0]        loadIdx,
  input logic [7:0]        loadData,
  input logic [ADDR_W-1:0] regPtr,
  input logic              expectAddr,
  input logic [7:0]        ctrlByte
);
  // R2: address byte loads the pointer
  assert_addr_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (expectAddr && rxValid && !startWr && !startRd) |=> regPtr == $past(rxData[ADDR_W-1:0]));

  // R4: a lone take advances the pointer modulo the bank size
  assert_take_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (txTake && !rxValid && !startWr && !startRd) |=> regPtr == ADDR_W'($past(regPtr) + 1));

  // R7: time write produces load pulse with index and byte
  assert_load_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !expectAddr && !startWr && !startRd && regPtr < 7)
      |=> (loadStb && loadIdx == $past(regPtr[2:0]) && loadData == $past(rxData)));

  // R7: no load pulse without a received byte
  assert_load_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    loadStb |-> $past(rxValid));

  // R8: zero bits of the control byte
  assert_ctrl_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlByte & 8'h4C) == 8'h00);

  // R10: oscillator-stop event sets the flag
  assert_osf_set_R10: assert property (@(posedge clk) disable iff (!rstN)
    oscStop |=> ctrlByte[5]);
endmodule

bind rtc_front rtc_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .startWr(startWr), .startRd(startRd),
  .rxValid(rxValid), .rxData(rxData), .txTake(txTake), .txData(txData),
  .oscStop(oscStop), .loadStb(loadStb), .loadIdx(loadIdx), .loadData(loadData),
  .regPtr(regPtr), .expectAddr(expectAddr), .ctrlByte(ctrlByte)
);

// File: tb/sim_rtc_front.sv
module sim_rtc_front;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startWr = 1'b0, startRd = 1'b0, rxValid = 1'b0, txTake = 1'b0, oscStop = 1'b0;
  logic [7:0]  rxData = '0;
  logic [55:0] liveTime = '0;
  logic [7:0]  txData;
  logic        loadStb;
  logic [2:0]  loadIdx;
  logic [7:0]  loadData;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  string tag = "R1";

  // reference model
  logic [7:0] mdl [64];
  int   mPtr = 0;
  bit   mExpect = 0;
  bit   expLoad = 0;
  int   expIdx = 0;
  logic [7:0] expData = '0;

  always #4 clk = ~clk;

  rtc_front u0 (
    .clk(clk), .rstN(rstN), .startWr(startWr), .startRd(startRd),
    .rxValid(rxValid), .rxData(rxData), .txTake(txTake), .txData(txData),
    .liveTime(liveTime), .oscStop(oscStop), .loadStb(loadStb),
    .loadIdx(loadIdx), .loadData(loadData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ctrlModel(input logic [7:0] old, input logic [7:0] d);
    logic [7:0] v;
    v = d & 8'hB3;
    v[5] = d[5] & old[5];
    return v;
  endfunction

  task automatic capture();
    for (int i = 0; i < 7; i++) mdl[i] = liveTime[i*8 +: 8];
  endtask

  task automatic advance();
    mPtr = (mPtr + 1) % 64;
    if (mPtr == 0) capture();
  endtask

  // one cycle: check outputs, drive inputs, update model
  task automatic step(input bit sw, input bit sr, input bit rv, input logic [7:0] d,
                      input bit tk, input bit osc);
    bit nLoad;
    @(negedge clk);
    chk(txData == mdl[mPtr], tag, "txData", txData, mdl[mPtr]);
    chk(loadStb == expLoad, "R7", "loadStb", loadStb, expLoad);
    if (expLoad) begin
      chk(loadIdx == expIdx[2:0], "R7", "loadIdx", loadIdx, expIdx);
      chk(loadData == expData, "R7", "loadData", loadData, expData);
    end
    startWr = sw; startRd = sr; rxValid = rv; rxData = d; txTake = tk; oscStop = osc;
    liveTime = {$urandom(), $urandom()};
    nLoad = 0;
    if (sw) mExpect = 1;
    else if (sr) capture();
    else if (rv) begin
      if (mExpect) begin
        mPtr = d & 8'h3F;
        mExpect = 0;
      end else begin
        if (mPtr < 7) begin
          nLoad = 1; expIdx = mPtr; expData = d;
        end else if (mPtr == 7) mdl[7] = ctrlModel(mdl[7], d);
        else mdl[mPtr] = d;
        advance();
      end
    end else if (tk) advance();
    if (osc) mdl[7][5] = 1'b1;
    expLoad = nLoad;
  endtask

  task automatic idle();
    step(0, 0, 0, 8'h00, 0, 0);
  endtask

  task automatic setPtr(input logic [7:0] a);
    step(1, 0, 0, 8'h00, 0, 0);
    step(0, 0, 1, a, 0, 0);
  endtask

  task automatic wrByte(input logic [7:0] d, input bit osc);
    step(0, 0, 1, d, 0, osc);
  endtask

  task automatic take();
    step(0, 0, 0, 8'h00, 1, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1: whole bank zero after reset (read without start)
    tag = "R1";
    for (int i = 0; i < 63; i++) take();
    // R6: the 64th take wraps and recaptures
    tag = "R6";
    take();
    idle();

    // R2: address byte masked to 6 bits, not stored; priority write-start first
    tag = "R2";
    setPtr(8'hC9);
    wrByte(8'h5A, 0);
    setPtr(8'h49);
    step(1, 1, 1, 8'hEE, 1, 0);  // write-start wins
    step(0, 0, 1, 8'h09, 0, 0);  // address byte
    idle();
    @(negedge clk);
    chk(txData == 8'h5A, "R2", "masked address readback", txData, 8'h5A);

    // R3: burst into general memory
    tag = "R3";
    setPtr(8'h10);
    for (int i = 0; i < 8; i++) wrByte(8'(8'h20 + i * 7), 0);
    setPtr(8'h10);
    for (int i = 0; i < 9; i++) take();

    // R5: read-start snapshot at location 0
    tag = "R5";
    setPtr(8'h00);
    step(0, 1, 0, 8'h00, 0, 0);
    for (int i = 0; i < 8; i++) take();

    // R6: wrap by writes from 62
    tag = "R6";
    setPtr(8'h3E);
    wrByte(8'hA1, 0);
    wrByte(8'hA2, 0);
    idle();
    take();

    // R7: time writes go out as load pulses, bank untouched
    tag = "R7";
    setPtr(8'h02);
    wrByte(8'h37, 0);
    wrByte(8'h12, 0);
    idle();
    setPtr(8'h02);
    take();

    // R8 / R9: control byte masking and clear-only flag
    tag = "R8";
    setPtr(8'h07);
    wrByte(8'hFF, 0);
    setPtr(8'h07);
    idle();
    @(negedge clk);
    chk(txData == 8'h93, "R8", "control masked", txData, 8'h93);
    tag = "R10";
    step(0, 0, 0, 8'h00, 0, 1);
    idle();
    tag = "R9";
    setPtr(8'h07);
    wrByte(8'hFF, 0);  // writing 1 keeps flag set
    setPtr(8'h07);
    idle();
    @(negedge clk);
    chk(txData == 8'hB3, "R9", "flag kept by write of 1", txData, 8'hB3);
    wrByte(8'h00, 0);  // clears
    setPtr(8'h07);
    idle();
    @(negedge clk);
    chk(txData == 8'h00, "R9", "flag cleared", txData, 8'h00);
    tag = "R10";
    wrByte(8'h00, 1);  // clear and set together: set wins
    setPtr(8'h07);
    idle();
    @(negedge clk);
    chk(txData[5] == 1'b1, "R10", "set beats clear", txData[5], 1);

    // random mix
    tag = "R4";
    for (int n = 0; n < 400; n++) begin
      int kind = $urandom % 4;
      if (kind == 0) begin
        setPtr(8'($urandom));
        for (int k = 0; k < 1 + $urandom % 6; k++)
          wrByte(8'($urandom), ($urandom % 16) == 0);
      end else if (kind == 1) begin
        step(0, 1, 0, 8'h00, 0, 0);
        for (int k = 0; k < 1 + $urandom % 10; k++) take();
      end else if (kind == 2) begin
        take();
      end else begin
        setPtr(8'(8'h38 + $urandom % 8));
        for (int k = 0; k < 10; k++) take();
      end
    end
    idle();
    idle();

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule